// File: doc/BRIEF.md
# Pipeline Load-Use Hazard Detector

This block decides, every cycle, whether the instruction in the decode stage of a five-stage in-order integer pipeline may advance. It looks at the register numbers the decoding instruction reads and compares them with the destinations of the instructions ahead of it, in execute and in memory. When the decoding instruction would read a value that is not yet available, it freezes the program counter and the fetch/decode pipeline register. In the same cycle it zeroes the control bits that enter execute, so a bubble goes down the pipe in place of the stalled instruction. The block is purely combinational, and its outputs follow its inputs within the same cycle.

A single parameter selects how the rest of the pipeline is built. With forwarding present, only a load followed directly by a consumer of its result has to wait, and it waits one cycle. If that stall were missing, the consumer would read the register's stale contents from before the load. With no forwarding, the decoding instruction waits while either the execute-stage or the memory-stage instruction still has a pending write to a register it reads. For the memory stage, the comparison uses the destination number that execute already chose and that travels in the execute/memory pipeline register. Both configurations drive the same three outputs.

The execute-stage destination is taken from the rd field for register-type operations and from the rt field for loads. A select input carries that choice. Register zero never creates a hazard. Each source is compared only when its use bit says the decoding instruction actually reads it.

Top module: `hazard_unit`

## Requirements
- R1: With no producer writing a register (all write flags low), pc_we=1, ifid_we=1 and idex_bubble=0 in both configurations.
- R2: ifid_we always equals pc_we, and idex_bubble is always the inverse of pc_we. A stall is pc_we=0.
- R3: In forwarding mode (MODE=HZD_MODE_FWD), a stall occurs when the execute-stage instruction is a load (ex_mem_read=1 and ex_reg_write=1) and its destination is nonzero and equals a used decode source.
- R4: In forwarding mode, neither an execute-stage non-load write (ex_mem_read=0) nor any memory-stage write causes a stall.
- R5: In no-forwarding mode (MODE=HZD_MODE_NOFWD), a stall occurs when ex_reg_write=1 and the execute destination is nonzero and equals a used decode source, whether or not the instruction is a load.
- R6: In no-forwarding mode, a stall occurs when mem_reg_write=1 and mem_dst is nonzero and equals a used decode source.
- R7: The execute destination is ex_rd when ex_dst_is_rd=1 and ex_rt when ex_dst_is_rd=0. The field that is not selected has no effect on the outputs.
- R8: A destination of register 0 never causes a stall.
- R9: A decode source whose use bit (id_use_a or id_use_b) is 0 never causes a stall.
- R10: A producer whose register-write flag is 0 never causes a stall, even when ex_mem_read=1.
- R11: In forwarding mode, a load-use stall lasts exactly one cycle. Once the bubble is in execute and the load has moved to memory, the stall clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_a | input | REG_AW | First source register number of the decoding instruction |
| id_use_a | input | 1 | id_src_a is read by the decoding instruction |
| id_src_b | input | REG_AW | Second source register number of the decoding instruction |
| id_use_b | input | 1 | id_src_b is read by the decoding instruction |
| ex_rt | input | REG_AW | rt field of the execute-stage instruction |
| ex_rd | input | REG_AW | rd field of the execute-stage instruction |
| ex_dst_is_rd | input | 1 | 1 selects ex_rd as the destination, 0 selects ex_rt |
| ex_mem_read | input | 1 | Execute-stage instruction is a load |
| ex_reg_write | input | 1 | Execute-stage instruction writes a register |
| mem_dst | input | REG_AW | Destination already selected, held in the execute/memory register |
| mem_reg_write | input | 1 | Memory-stage instruction writes a register |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode pipeline register write enable |
| idex_bubble | output | 1 | Zero the control bits entering execute |

## Verification
Because the block holds no state, any fault shows at the ports in the same cycle the offending input pattern appears. A wrong comparison or qualifier shows up as a missing stall or a spurious one. In a missing stall the consumer would read a stale value. A spurious stall only costs a cycle, but it shows up as pc_we low while no producer matches. A fault in the output stage shows as ifid_we or idex_bubble drifting from their fixed relation to pc_we. The bench drives both configurations side by side with the same inputs, so a difference confined to one mode is caught on the vector that triggers it.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic {
    HZD_MODE_NOFWD = 1'b0,
    HZD_MODE_FWD   = 1'b1
  } hzd_mode_e;

  localparam int unsigned HZD_NUM_SRC = 2;
endpackage

// File: rtl/hzd_dst_pick.sv
module hzd_dst_pick #(
  parameter int unsigned AW = 5
) (
  input  logic          sel_rd,
  input  logic [AW-1:0] rt_fld,
  input  logic [AW-1:0] rd_fld,
  output logic [AW-1:0] dst
);
  always_comb begin
    dst = sel_rd ? rd_fld : rt_fld;
  end
endmodule

// File: rtl/hzd_src_cmp.sv
module hzd_src_cmp #(
  parameter int unsigned AW   = 5,
  parameter int unsigned NSRC = 2
) (
  input  logic [NSRC-1:0][AW-1:0] srcs,
  input  logic [NSRC-1:0]         used,
  input  logic [AW-1:0]           dst,
  input  logic                    wr_en,
  output logic                    hit
);
  logic [NSRC-1:0] per_src;
  logic            dst_live;

  assign dst_live = wr_en && (dst != '0);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign per_src[g] = used[g] && (srcs[g] == dst);
  end

  assign hit = dst_live && (|per_src);
endmodule

// File: rtl/hzd_stall_drv.sv
module hzd_stall_drv (
  input  logic stall,
  output logic pc_we,
  output logic ifid_we,
  output logic idex_bubble
);
  always_comb begin
    pc_we       = ~stall;
    ifid_we     = ~stall;
    idex_bubble = stall;
  end
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hzd_pkg::*;
#(
  parameter hzd_mode_e   MODE   = HZD_MODE_FWD,
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] id_src_a,
  input  logic              id_use_a,
  input  logic [REG_AW-1:0] id_src_b,
  input  logic              id_use_b,
  input  logic [REG_AW-1:0] ex_rt,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_dst_is_rd,
  input  logic              ex_mem_read,
  input  logic              ex_reg_write,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_reg_write,
  output logic              pc_we,
  output logic              ifid_we,
  output logic              idex_bubble
);
  localparam bit CHECK_ALL = (MODE == HZD_MODE_NOFWD);

  logic [HZD_NUM_SRC-1:0][REG_AW-1:0] src_vec;
  logic [HZD_NUM_SRC-1:0]             use_vec;
  logic [REG_AW-1:0]                  ex_dst;
  logic                               ex_en;
  logic                               mem_en;
  logic                               ex_hit;
  logic                               mem_hit;
  logic                               stall;

  assign src_vec = {id_src_b, id_src_a};
  assign use_vec = {id_use_b, id_use_a};

  // forwarding covers everything except a load's data one slot later
  assign ex_en  = ex_reg_write && (ex_mem_read || CHECK_ALL);
  assign mem_en = mem_reg_write && CHECK_ALL;

  hzd_dst_pick #(.AW(REG_AW)) ex_pick_i (
    .sel_rd (ex_dst_is_rd),
    .rt_fld (ex_rt),
    .rd_fld (ex_rd),
    .dst    (ex_dst)
  );

  hzd_src_cmp #(.AW(REG_AW), .NSRC(HZD_NUM_SRC)) ex_cmp_i (
    .srcs  (src_vec),
    .used  (use_vec),
    .dst   (ex_dst),
    .wr_en (ex_en),
    .hit   (ex_hit)
  );

  hzd_src_cmp #(.AW(REG_AW), .NSRC(HZD_NUM_SRC)) mem_cmp_i (
    .srcs  (src_vec),
    .used  (use_vec),
    .dst   (mem_dst),
    .wr_en (mem_en),
    .hit   (mem_hit)
  );

  assign stall = ex_hit || mem_hit;

  hzd_stall_drv drv_i (
    .stall       (stall),
    .pc_we       (pc_we),
    .ifid_we     (ifid_we),
    .idex_bubble (idex_bubble)
  );
endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk
  import hzd_pkg::*;
#(
  parameter hzd_mode_e   MODE = HZD_MODE_FWD,
  parameter int unsigned AW   = 5
) (
  input logic [AW-1:0] id_src_a,
  input logic          id_use_a,
  input logic [AW-1:0] id_src_b,
  input logic          id_use_b,
  input logic [AW-1:0] ex_rt,
  input logic [AW-1:0] ex_rd,
  input logic          ex_dst_is_rd,
  input logic          ex_mem_read,
  input logic          ex_reg_write,
  input logic [AW-1:0] mem_dst,
  input logic          mem_reg_write,
  input logic          pc_we,
  input logic          ifid_we,
  input logic          idex_bubble
);
  logic [AW-1:0] load_dst;
  logic          load_use;
  logic          no_src;

  assign load_dst = ex_dst_is_rd ? ex_rd : ex_rt;
  assign load_use = ex_mem_read && ex_reg_write && (load_dst != '0) &&
                    ((id_use_a && id_src_a == load_dst) ||
                     (id_use_b && id_src_b == load_dst));
  assign no_src   = !id_use_a && !id_use_b;

  always_comb begin
    AST_FETCH_TIED: assert (ifid_we == pc_we);                      // R2
    AST_BUBBLE_INV: assert (idex_bubble == !pc_we);                 // R2
    AST_LOAD_USE_STALL: assert (!load_use || !pc_we);               // R3
    AST_NO_SRC_NO_STALL: assert (!no_src || pc_we);                 // R9
    AST_NO_WRITER_NO_STALL: assert (ex_reg_write || mem_reg_write || pc_we); // R10
    AST_FWD_ALU_FREE: assert (!(MODE == HZD_MODE_FWD && !ex_mem_read) || pc_we); // R4
  end
endmodule

bind hazard_unit hazard_unit_chk #(.MODE(MODE), .AW(REG_AW)) chk_i (
  .id_src_a      (id_src_a),
  .id_use_a      (id_use_a),
  .id_src_b      (id_src_b),
  .id_use_b      (id_use_b),
  .ex_rt         (ex_rt),
  .ex_rd         (ex_rd),
  .ex_dst_is_rd  (ex_dst_is_rd),
  .ex_mem_read   (ex_mem_read),
  .ex_reg_write  (ex_reg_write),
  .mem_dst       (mem_dst),
  .mem_reg_write (mem_reg_write),
  .pc_we         (pc_we),
  .ifid_we       (ifid_we),
  .idex_bubble   (idex_bubble)
);

// File: tb/hazard_unit_tb_top.sv
module hazard_unit_tb_top;
  import hzd_pkg::*;

  localparam int AW = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [AW-1:0] sa, sb, ext, exd, md;
  logic ua, ub, exsel, exmr, exrw, mrw;
  logic f_pc, f_ifid, f_bub, n_pc, n_ifid, n_bub;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  hazard_unit #(.MODE(HZD_MODE_FWD), .REG_AW(AW)) dut_i (
    .id_src_a(sa), .id_use_a(ua), .id_src_b(sb), .id_use_b(ub),
    .ex_rt(ext), .ex_rd(exd), .ex_dst_is_rd(exsel),
    .ex_mem_read(exmr), .ex_reg_write(exrw),
    .mem_dst(md), .mem_reg_write(mrw),
    .pc_we(f_pc), .ifid_we(f_ifid), .idex_bubble(f_bub)
  );

  hazard_unit #(.MODE(HZD_MODE_NOFWD), .REG_AW(AW)) dut_nf_i (
    .id_src_a(sa), .id_use_a(ua), .id_src_b(sb), .id_use_b(ub),
    .ex_rt(ext), .ex_rd(exd), .ex_dst_is_rd(exsel),
    .ex_mem_read(exmr), .ex_reg_write(exrw),
    .mem_dst(md), .mem_reg_write(mrw),
    .pc_we(n_pc), .ifid_we(n_ifid), .idex_bubble(n_bub)
  );

  function automatic bit reads(logic [AW-1:0] d);
    return (d != '0) && ((ua && sa == d) || (ub && sb == d));
  endfunction

  function automatic bit model_stall(bit fwd);
    logic [AW-1:0] ed;
    ed = exsel ? exd : ext;
    if (fwd) return exrw && exmr && reads(ed);
    return (exrw && reads(ed)) || (mrw && reads(md));
  endfunction

  task automatic chk(string tag, string what, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%0b exp=%0b", tag, what, got, exp);
    end
  endtask

  task automatic check_both(string tag);
    bit sf, sn;
    sf = model_stall(1'b1);
    sn = model_stall(1'b0);
    chk(tag, "fwd pc_we", f_pc, !sf);
    chk(tag, "fwd ifid_we R2", f_ifid, !sf);
    chk(tag, "fwd idex_bubble R2", f_bub, sf);
    chk(tag, "nofwd pc_we", n_pc, !sn);
    chk(tag, "nofwd ifid_we R2", n_ifid, !sn);
    chk(tag, "nofwd idex_bubble R2", n_bub, sn);
  endtask

  task automatic clear_in();
    sa = '0; sb = '0; ext = '0; exd = '0; md = '0;
    ua = 0; ub = 0; exsel = 0; exmr = 0; exrw = 0; mrw = 0;
  endtask

  task automatic settle();
    #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #100000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    clear_in();
    @(negedge clk);
    // R1 idle state
    ua = 1; ub = 1; sa = 3; sb = 4; settle();
    chk("R1", "fwd pc_we", f_pc, 1'b1);
    chk("R1", "nofwd bubble", n_bub, 1'b0);

    // R3 load into rt, consumer on source a
    @(negedge clk); clear_in();
    ua = 1; sa = 3; ext = 3; exmr = 1; exrw = 1; settle();
    chk("R3", "fwd pc_we", f_pc, 1'b0);
    check_both("R3 srcA");

    // R3 consumer on source b
    @(negedge clk); clear_in();
    ub = 1; sb = 9; ext = 9; exmr = 1; exrw = 1; settle();
    check_both("R3 srcB");

    // R4/R5 ALU result in execute
    @(negedge clk); clear_in();
    ua = 1; sa = 4; exsel = 1; exd = 4; exrw = 1; settle();
    chk("R4", "fwd pc_we", f_pc, 1'b1);
    chk("R5", "nofwd pc_we", n_pc, 1'b0);

    // R4/R6 memory-stage writer
    @(negedge clk); clear_in();
    ub = 1; sb = 5; md = 5; mrw = 1; settle();
    chk("R4", "fwd pc_we mem", f_pc, 1'b1);
    chk("R6", "nofwd pc_we mem", n_pc, 1'b0);

    // R7 destination field select
    @(negedge clk); clear_in();
    ua = 1; sa = 7; exsel = 1; exd = 6; ext = 7; exrw = 1; exmr = 1; settle();
    chk("R7", "fwd unselected rt", f_pc, 1'b1);
    chk("R7", "nofwd unselected rt", n_pc, 1'b1);
    sa = 6; settle();
    chk("R7", "fwd selected rd", f_pc, 1'b0);

    // R8 register zero
    @(negedge clk); clear_in();
    ua = 1; ub = 1; ext = 0; exmr = 1; exrw = 1; md = 0; mrw = 1; settle();
    chk("R8", "fwd pc_we", f_pc, 1'b1);
    chk("R8", "nofwd pc_we", n_pc, 1'b1);

    // R9 unused sources
    @(negedge clk); clear_in();
    sa = 2; sb = 2; ext = 2; exmr = 1; exrw = 1; md = 2; mrw = 1; settle();
    chk("R9", "fwd pc_we", f_pc, 1'b1);
    chk("R9", "nofwd pc_we", n_pc, 1'b1);

    // R10 write flags low
    @(negedge clk); clear_in();
    ua = 1; sa = 8; ext = 8; exmr = 1; md = 8; settle();
    chk("R10", "fwd pc_we", f_pc, 1'b1);
    chk("R10", "nofwd pc_we", n_pc, 1'b1);

    // R11 load-use sequence
    @(negedge clk); clear_in();
    ua = 1; sa = 3; ext = 3; exmr = 1; exrw = 1; settle();
    chk("R11", "cycle1 fwd stall", f_pc, 1'b0);
    @(negedge clk);
    exmr = 0; exrw = 0; ext = 0; md = 3; mrw = 1; settle();
    chk("R11", "cycle2 fwd released", f_pc, 1'b1);
    chk("R11", "cycle2 nofwd still", n_pc, 1'b0);
    @(negedge clk);
    md = 0; mrw = 0; settle();
    chk("R11", "cycle3 nofwd released", n_pc, 1'b1);

    // random mix, small register range for frequent matches
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      sa = AW'($urandom_range(0, 3)); sb = AW'($urandom_range(0, 3));
      ext = AW'($urandom_range(0, 3)); exd = AW'($urandom_range(0, 3));
      md = AW'($urandom_range(0, 3));
      ua = 1'($urandom); ub = 1'($urandom); exsel = 1'($urandom);
      exmr = 1'($urandom); exrw = 1'($urandom); mrw = 1'($urandom);
      settle();
      check_both("random R3 R5 R6");
    end

    finish_run();
  end
endmodule